// File: doc/BRIEF.md
# Line Brownout Detector with Timed Hysteresis

This block decides whether a power-factor front end may keep switching when the mains input sags. It watches a peak value of the rectified line, delivered as a code together with a one-cycle strobe about once per half line cycle. It compares that peak against two threshold codes, a lower one and an upper one. Elapsed time is measured by counting a periodic timebase tick, not clock cycles.

In normal operation a dwell timer runs while the held peak is at or below the lower threshold. When that timer goes beyond the qualification window, the block declares a brownout. Declaring a brownout drops the gate-drive enable and signals a request for standby. While in brownout the block keeps watching the line. A second dwell timer runs while the peak is strictly above the upper threshold, and normal operation returns only when that timer also goes beyond the window. A single excursion across either threshold is never enough to change the state. A peak that lies between the two thresholds holds whichever state is current.

Top module: `line_brownout_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `brownout` is 0 and `gate_en` is 1. Reset clears both dwell timers and loads the held peak with the all-ones code, so reset alone never starts the entry timer.
- R2: The held peak changes only in a cycle where `peak_valid` is 1. A `peak_code` presented without the strobe has no effect on the state.
- R3: In normal state, every `time_tick` for which the held peak is less than or equal to `thr_low` advances the entry timer. `brownout` rises at the clock edge of the (DWELL_TICKS+1)-th consecutive such tick.
- R4: Any cycle in normal state with the held peak above `thr_low` returns the entry timer to zero, so the next qualifying run begins again from one.
- R5: In brownout state, every `time_tick` for which the held peak is strictly greater than `thr_high` advances the exit timer. `brownout` falls at the clock edge of the (DWELL_TICKS+1)-th consecutive such tick.
- R6: Any cycle in brownout state with the held peak less than or equal to `thr_high` returns the exit timer to zero.
- R7: `gate_en` is always the inverse of `brownout`, and both are registered.
- R8: A held peak strictly between `thr_low` and `thr_high` leaves the current state unchanged for any number of ticks.
- R9: `brownout` changes only at an edge whose cycle carried `time_tick`. No number of clock cycles without ticks changes the state.
- R10: The worked case uses a 0.1 ms tick, DWELL_TICKS = 560, codes of 1/16 V, and a lower threshold of 95 V (code 1520). The peak holds at 128 V (code 2048) for 8 ms and then falls 5 V every 8 ms, which is one code per tick. In this case the brownout is declared on tick 1168, that is 116.8 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| peak_valid | input | 1 | One-cycle strobe marking a new line peak |
| peak_code | input | PEAK_W | Line peak code, captured when `peak_valid` is 1 |
| time_tick | input | 1 | One-cycle timebase pulse |
| thr_low | input | PEAK_W | Lower threshold code (entry side) |
| thr_high | input | PEAK_W | Upper threshold code (exit side), above `thr_low` |
| brownout | output | 1 | 1 while a brownout is declared (standby request) |
| gate_en | output | 1 | Gate-drive enable, 1 in normal operation |

## Verification
The main function is driven with a slow linear descent that reproduces the 116.8 ms response. It is also driven with a sag that recovers for a single sample just short of the window, which separates a timer that is cleared from one that merely pauses. On the exit side the peak is allowed to touch the upper threshold exactly, which exposes off-by-one errors in the strict and inclusive comparisons. Further patterns cover long stays inside the hysteresis band in each state, codes presented without the strobe, long tick-free stretches, and a reset taken while in brownout. Each pattern checks the exact tick on which the state flips and the tick just before it.

// File: rtl/lbo_pkg.sv
package lbo_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_BROWN = 1'b1
  } lbo_state_e;

  localparam int unsigned TMR_ENTRY = 0;
  localparam int unsigned TMR_EXIT  = 1;
  localparam int unsigned TMR_COUNT = 2;
endpackage

// File: rtl/lbo_peak_hold.sv
module lbo_peak_hold #(
  parameter int unsigned PEAK_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              peak_valid,
  input  logic [PEAK_W-1:0] peak_code,
  input  logic [PEAK_W-1:0] thr_low,
  input  logic [PEAK_W-1:0] thr_high,
  output logic              sag_low,
  output logic              good_high
);
  logic [PEAK_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '1;
    end else if (peak_valid) begin
      held_q <= peak_code;
    end
  end

  // Inclusive on the entry side, strict on the exit side.
  always_comb begin
    sag_low   = (held_q <= thr_low);
    good_high = (held_q > thr_high);
  end

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !peak_valid |=> $stable(held_q));
endmodule

// File: rtl/lbo_dwell_timer.sv
module lbo_dwell_timer #(
  parameter int unsigned DWELL_TICKS = 56,
  parameter int unsigned CNT_W = $clog2(DWELL_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             cond,
  input  logic             tick,
  output logic             fire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run   = arm && cond;
  assign fire  = run && tick && (cnt_q == LIMIT);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LIMIT) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r4_clear_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/lbo_state_ctrl.sv
module lbo_state_ctrl
  import lbo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enter_fire,
  input  logic leave_fire,
  output logic in_brown,
  output logic brownout,
  output logic gate_en
);
  lbo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (enter_fire) state_d = ST_BROWN;
      ST_BROWN: if (leave_fire) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      brownout <= 1'b0;
      gate_en  <= 1'b1;
    end else begin
      state_q  <= state_d;
      brownout <= (state_d == ST_BROWN);
      gate_en  <= (state_d != ST_BROWN);
    end
  end

  assign in_brown = (state_q == ST_BROWN);

  a_r7_gate_inverse: assert property (@(posedge clk) disable iff (rst)
    gate_en != brownout);
endmodule

// File: rtl/line_brownout_guard.sv
module line_brownout_guard
  import lbo_pkg::*;
#(
  parameter int unsigned PEAK_W      = 12,
  parameter int unsigned DWELL_TICKS = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              peak_valid,
  input  logic [PEAK_W-1:0] peak_code,
  input  logic              time_tick,
  input  logic [PEAK_W-1:0] thr_low,
  input  logic [PEAK_W-1:0] thr_high,
  output logic              brownout,
  output logic              gate_en
);
  localparam int unsigned CNT_W = $clog2(DWELL_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_TICKS);

  logic sag_low, good_high, in_brown;
  logic [TMR_COUNT-1:0] arm_v, cond_v, fire_v;
  logic [CNT_W-1:0] cnt_v [TMR_COUNT];

  lbo_peak_hold #(.PEAK_W(PEAK_W)) u_hold (
    .clk(clk), .rst(rst), .peak_valid(peak_valid), .peak_code(peak_code),
    .thr_low(thr_low), .thr_high(thr_high),
    .sag_low(sag_low), .good_high(good_high)
  );

  assign arm_v[TMR_ENTRY]  = !in_brown;
  assign cond_v[TMR_ENTRY] = sag_low;
  assign arm_v[TMR_EXIT]   = in_brown;
  assign cond_v[TMR_EXIT]  = good_high;

  for (genvar i = 0; i < TMR_COUNT; i++) begin : g_tmr
    lbo_dwell_timer #(.DWELL_TICKS(DWELL_TICKS), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .arm(arm_v[i]), .cond(cond_v[i]),
      .tick(time_tick), .fire(fire_v[i]), .count(cnt_v[i])
    );
  end

  lbo_state_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .enter_fire(fire_v[TMR_ENTRY]), .leave_fire(fire_v[TMR_EXIT]),
    .in_brown(in_brown), .brownout(brownout), .gate_en(gate_en)
  );

  a_r3_entry_after_dwell: assert property (@(posedge clk) disable iff (rst)
    $rose(brownout) |-> $past(cnt_v[TMR_ENTRY] == LIMIT && time_tick));
  a_r5_exit_after_dwell: assert property (@(posedge clk) disable iff (rst)
    $fell(brownout) |-> $past(cnt_v[TMR_EXIT] == LIMIT && time_tick));
  a_r9_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    (brownout != $past(brownout)) |-> $past(time_tick));
  a_r6_exit_idle_in_run: assert property (@(posedge clk) disable iff (rst)
    !brownout |-> (cnt_v[TMR_EXIT] == '0));
endmodule

// File: tb/line_brownout_guard_test.sv
module line_brownout_guard_test;
  localparam int unsigned PW = 12;
  localparam int unsigned DW = 560;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic peak_valid = 1'b0;
  logic [PW-1:0] peak_code = '0;
  logic time_tick = 1'b0;
  logic [PW-1:0] thr_low = 12'd1520;
  logic [PW-1:0] thr_high = 12'd1700;
  logic brownout, gate_en;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  line_brownout_guard #(.PEAK_W(PW), .DWELL_TICKS(DW)) uut (
    .clk(clk), .rst(rst), .peak_valid(peak_valid), .peak_code(peak_code),
    .time_tick(time_tick), .thr_low(thr_low), .thr_high(thr_high),
    .brownout(brownout), .gate_en(gate_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One tick period: present a strobed peak, then one timebase tick.
  task automatic step(input int v, input bit strobe);
    @(negedge clk);
    peak_code = PW'(v);
    peak_valid = strobe;
    @(negedge clk);
    peak_valid = 1'b0;
    time_tick = 1'b1;
    @(negedge clk);
    time_tick = 1'b0;
  endtask

  // Runs n steps; returns the 1-based step on which brownout first changed, 0 if never.
  task automatic run(input int v, input bit strobe, input int n, output int first);
    logic start;
    start = brownout;
    first = 0;
    for (int k = 1; k <= n; k++) begin
      step(v, strobe);
      if (first == 0 && brownout != start) first = k;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(brownout == 1'b0, "R1 brownout in reset", brownout, 0);
    check(gate_en == 1'b1, "R1 gate_en in reset", gate_en, 1);
    rst = 1'b0;
    @(negedge clk);
    check(brownout == 1'b0 && gate_en == 1'b1, "R1 after reset", brownout, 0);
  endtask

  task automatic t_worked_case;
    int first = 0;
    for (int n = 1; n <= 1168; n++) begin
      step((n <= 80) ? 2048 : 2048 - (n - 80), 1'b1);
      if (first == 0 && brownout) first = n;
    end
    check(first == 1168, "R10 response tick (x0.1 ms)", first, 1168);
    check(first == 1168, "R3 entry on dwell+1 qualifying tick", first, 1168);
    check(gate_en == 1'b0, "R7 gate off in brownout", gate_en, 0);
  endtask

  task automatic t_exit;
    int f;
    run(2048, 1'b1, 561, f);
    check(f == 561, "R5 exit on dwell+1 tick", f, 561);
    check(gate_en == 1'b1, "R7 gate back on", gate_en, 1);
  endtask

  task automatic t_entry_bounce;
    int f;
    run(1500, 1'b1, 300, f);
    check(f == 0, "R3 no entry at 300", f, 0);
    run(1600, 1'b1, 1, f);
    check(f == 0, "R4 bounce no entry", f, 0);
    run(1500, 1'b1, 561, f);
    check(f == 561, "R4 timer restarted from zero", f, 561);
  endtask

  task automatic t_exit_bounce;
    int f;
    run(1800, 1'b1, 300, f);
    check(f == 0, "R5 no exit at 300", f, 0);
    run(1700, 1'b1, 1, f);
    check(f == 0 && brownout, "R6 equal to upper holds", f, 0);
    run(1800, 1'b1, 561, f);
    check(f == 561, "R6 exit timer restarted", f, 561);
  endtask

  task automatic t_band;
    int f;
    run(1600, 1'b1, 1000, f);
    check(f == 0 && !brownout, "R8 band holds normal", brownout, 0);
    run(1500, 1'b1, 561, f);
    check(f == 561, "R3 re-entry", f, 561);
    run(1600, 1'b1, 1000, f);
    check(f == 0 && brownout, "R8 band holds brownout", brownout, 1);
    run(1800, 1'b1, 561, f);
    check(f == 561, "R5 exit from band", f, 561);
  endtask

  task automatic t_no_strobe;
    int f;
    run(1000, 1'b0, 700, f);
    check(f == 0 && !brownout, "R2 unstrobed code ignored", brownout, 0);
  endtask

  task automatic t_no_tick;
    @(negedge clk);
    peak_code = 12'd1000;
    peak_valid = 1'b1;
    @(negedge clk);
    peak_valid = 1'b0;
    repeat (2000) @(negedge clk);
    check(brownout == 1'b0, "R9 no change without ticks", brownout, 0);
  endtask

  task automatic t_mid_reset;
    int f;
    run(1000, 1'b1, 561, f);
    check(brownout == 1'b1, "R3 enter before reset", brownout, 1);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(brownout == 1'b0 && gate_en == 1'b1, "R1 reset leaves brownout", brownout, 0);
    run(1000, 1'b0, 600, f);
    check(f == 0, "R1 held peak reset to all ones", f, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_worked_case();
        t_exit();
        t_entry_bounce();
        t_exit_bounce();
        t_band();
        t_no_strobe();
        t_no_tick();
        t_mid_reset();
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule